// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous page-mode DRAM out of power-up and then keeps its contents alive. After reset it takes over the shared strobe lines and waits out a long settling pause. It then runs a fixed number of dummy refresh cycles before it reports the memory as usable. No host access may happen before that point. All timing is counted in clock cycles of the system clock. Every interval is a parameter.

Once the DRAM is ready, a free-running interval counter builds up a count of owed refreshes. The block raises a request to the access controller. When the grant comes back, which happens only after any open row has been closed, the block drives a refresh cycle in which CAS is driven low before RAS. No external row address is needed for this. If a second interval expires before the first owed refresh has been served, an overdue flag is raised. Both owed refreshes are then run back to back. A low-power input moves the DRAM into self refresh. The block holds RAS and CAS low for at least the minimum self-refresh time, and never for a length inside the forbidden window. On exit it applies the longer self-refresh precharge.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset until initialization ends, `busOwn` is 1, `rfshReq` is 0, `initDone` is 0, and RAS stays high for at least `INIT_PAUSE` cycles after reset is released.
- R2: After the pause, exactly `INIT_CYCLES` refresh cycles run without any grant, and then `initDone` becomes 1 and `busOwn` drops to 0.
- R3: At every RAS falling edge, CAS has already been low for at least `T_CSR` cycles. CAS stays low for the first `T_CHR` cycles of RAS low. CAS is high whenever RAS rises.
- R4: A normal refresh holds RAS low for exactly `T_RAS` cycles. RAS then stays high for at least `T_RP` cycles before the next fall.
- R5: After initialization, one refresh is owed every `REF_INTERVAL` cycles. When the grant is held high, consecutive RAS falls are exactly `REF_INTERVAL` cycles apart.
- R6: After initialization, the block leaves the idle state (`busOwn` rising) only in a cycle where `rfshGnt` was sampled 1. While the grant is withheld, RAS stays high and `rfshReq` stays 1.
- R7: When two refreshes are owed, `overdue` is 1 and `rfshReq` is 1. Once granted, both refreshes run back to back. Their RAS falls are `T_CSR+T_RAS+T_RP+1` cycles apart. Afterwards `overdue` and `rfshReq` are 0.
- R8: On a granted `srEnter`, RAS and CAS are held low with `srActive` at 1 for at least `SR_MIN` cycles. This holds even if `srEnter` is withdrawn earlier.
- R9: After self refresh ends, `busOwn` stays 1 with RAS and CAS high for exactly `T_RPS` cycles.
- R10: Entering self refresh discards all owed refreshes and restarts the interval count. Right after exit, `rfshReq` is 0 and stays 0 for at least half an interval.
- R11: A RAS-low duration is never at least `SR_MIN/10` cycles and below `SR_MIN` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rfshGnt | input | 1 | Grant from the access controller; held while `rfshReq` is 1 |
| srEnter | input | 1 | Level request to enter and stay in self refresh |
| rfshReq | output | 1 | Request for the shared strobe lines |
| busOwn | output | 1 | The sequencer is driving the strobe lines |
| initDone | output | 1 | Power-up sequence is complete; accesses allowed |
| overdue | output | 1 | Two or more refreshes are owed |
| srActive | output | 1 | DRAM is held in self refresh |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe for both byte lanes, active low |

## Verification
The hardest case to reach from the ports is a self-refresh entry while refreshes are still owed. Proving that the owed count is dropped needs a quiet request line after exit. The bench first withholds the grant until a request is raised. It then asserts `srEnter` together with the grant, withdraws `srEnter` well before the minimum hold, and watches the exit precharge and the request line afterwards. The overdue case is reached the same way, by starving the grant across two intervals.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE, ST_IDLE, ST_CSR, ST_RASLO, ST_PRE, ST_SRHOLD, ST_SRSTAY, ST_SRPRE
  } seqState_t;

  typedef enum logic [2:0] {
    LD_CSR, LD_RAS, LD_RP, LD_SRMIN, LD_RPS
  } tmrSel_t;

  typedef struct packed {
    logic    tmrLoad;
    tmrSel_t tmrSel;
    logic    initStep;
    logic    owedServe;
    logic    owedClear;
    logic    ivlHold;
  } seqCtl_t;

endpackage

// File: rtl/dram_rfsh_dp.sv
module dram_rfsh_dp
  import dram_rfsh_pkg::*;
#(
  parameter int INIT_PAUSE   = 40000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 3120,
  parameter int T_CSR        = 1,
  parameter int T_CHR        = 2,
  parameter int T_RAS        = 10,
  parameter int T_RP         = 8,
  parameter int T_RPS        = 22,
  parameter int SR_MIN       = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seqCtl_t    ctl,
  input  logic       initDone,
  output logic       tmrZero,
  output logic       casHold,
  output logic       initLast,
  output logic [1:0] owedCnt
);
  localparam int BIG_A   = (INIT_PAUSE > SR_MIN) ? INIT_PAUSE : SR_MIN;
  localparam int TMR_MAX = (BIG_A > T_RPS) ? BIG_A : T_RPS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int IVL_W   = $clog2(REF_INTERVAL + 1);
  localparam int INIT_W  = $clog2(INIT_CYCLES + 1);

  logic [TMR_W-1:0]  tmr, tmrLoadVal;
  logic [IVL_W-1:0]  ivl;
  logic [INIT_W-1:0] initCnt;
  logic              ivlExpire;

  // phase timer load values
  always_comb begin
    case (ctl.tmrSel)
      LD_CSR:   tmrLoadVal = TMR_W'(T_CSR - 1);
      LD_RAS:   tmrLoadVal = TMR_W'(T_RAS - 1);
      LD_RP:    tmrLoadVal = TMR_W'(T_RP - 1);
      LD_SRMIN: tmrLoadVal = TMR_W'(SR_MIN - 1);
      default:  tmrLoadVal = TMR_W'(T_RPS - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 tmr <= TMR_W'(INIT_PAUSE - 1);
    else if (ctl.tmrLoad)       tmr <= tmrLoadVal;
    else if (tmr != '0)         tmr <= tmr - 1'b1;
  end

  assign tmrZero = (tmr == '0);
  assign casHold = (tmr >= TMR_W'(T_RAS - T_CHR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            initCnt <= INIT_W'(INIT_CYCLES - 1);
    else if (ctl.initStep) initCnt <= initCnt - 1'b1;
  end
  assign initLast = (initCnt == '0);

  // refresh interval counter
  assign ivlExpire = initDone && !ctl.ivlHold && (ivl == IVL_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ivl <= '0;
    else if (!initDone || ctl.ivlHold) ivl <= '0;
    else if (ivlExpire)                ivl <= '0;
    else                               ivl <= ivl + 1'b1;
  end

  // owed refresh count, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owedCnt <= '0;
    else if (ctl.owedClear) owedCnt <= '0;
    else begin
      case ({ivlExpire, ctl.owedServe && (owedCnt != '0)})
        2'b10:   owedCnt <= (owedCnt == 2'd3) ? owedCnt : owedCnt + 1'b1;
        2'b01:   owedCnt <= owedCnt - 1'b1;
        default: owedCnt <= owedCnt;
      endcase
    end
  end
endmodule

// File: rtl/dram_rfsh_ctl.sv
module dram_rfsh_ctl
  import dram_rfsh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rfshGnt,
  input  logic       srEnter,
  input  logic       tmrZero,
  input  logic       casHold,
  input  logic       initLast,
  input  logic [1:0] owedCnt,
  output seqCtl_t    ctl,
  output logic       initDone,
  output logic       rfshReq,
  output logic       busOwn,
  output logic       overdue,
  output logic       srActive,
  output logic       rasN,
  output logic       casN
);
  seqState_t state, stateNxt;
  logic      srPath, srSet, srClr, initSet;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    srSet    = 1'b0;
    srClr    = 1'b0;
    initSet  = 1'b0;
    ctl.ivlHold = srPath;
    case (state)
      ST_PAUSE: if (tmrZero) begin
        stateNxt = ST_CSR; ctl.tmrLoad = 1'b1; ctl.tmrSel = LD_CSR;
      end
      ST_IDLE: if (initDone && rfshGnt && srEnter) begin
        stateNxt = ST_CSR; ctl.tmrLoad = 1'b1; ctl.tmrSel = LD_CSR;
        ctl.owedClear = 1'b1; srSet = 1'b1;
      end else if (initDone && rfshGnt && owedCnt != 2'd0) begin
        stateNxt = ST_CSR; ctl.tmrLoad = 1'b1; ctl.tmrSel = LD_CSR;
      end
      ST_CSR: if (tmrZero) begin
        ctl.tmrLoad = 1'b1;
        if (srPath) begin stateNxt = ST_SRHOLD; ctl.tmrSel = LD_SRMIN; end
        else        begin stateNxt = ST_RASLO;  ctl.tmrSel = LD_RAS;   end
      end
      ST_RASLO: if (tmrZero) begin
        stateNxt = ST_PRE; ctl.tmrLoad = 1'b1; ctl.tmrSel = LD_RP;
      end
      ST_PRE: if (tmrZero) begin
        if (!initDone) begin
          if (initLast) begin stateNxt = ST_IDLE; initSet = 1'b1; end
          else begin
            stateNxt = ST_CSR; ctl.initStep = 1'b1;
            ctl.tmrLoad = 1'b1; ctl.tmrSel = LD_CSR;
          end
        end else begin
          stateNxt = ST_IDLE; ctl.owedServe = 1'b1;
        end
      end
      ST_SRHOLD: if (tmrZero) stateNxt = ST_SRSTAY;
      ST_SRSTAY: if (!srEnter) begin
        stateNxt = ST_SRPRE; ctl.tmrLoad = 1'b1; ctl.tmrSel = LD_RPS;
      end
      ST_SRPRE: if (tmrZero) begin
        stateNxt = ST_IDLE; srClr = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PAUSE;
      initDone <= 1'b0;
      srPath   <= 1'b0;
    end else begin
      state <= stateNxt;
      if (initSet) initDone <= 1'b1;
      if (srSet)      srPath <= 1'b1;
      else if (srClr) srPath <= 1'b0;
    end
  end

  assign srActive = (state == ST_SRHOLD) || (state == ST_SRSTAY);
  assign rasN     = !((state == ST_RASLO) || srActive);
  assign casN     = !((state == ST_CSR) || ((state == ST_RASLO) && casHold) || srActive);
  assign busOwn   = !initDone || (state != ST_IDLE);
  assign rfshReq  = initDone && ((state != ST_IDLE) || (owedCnt != 2'd0) || srEnter);
  assign overdue  = owedCnt[1];
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int INIT_PAUSE   = 40000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 3120,
  parameter int T_CSR        = 1,
  parameter int T_CHR        = 2,
  parameter int T_RAS        = 10,
  parameter int T_RP         = 8,
  parameter int T_RPS        = 22,
  parameter int SR_MIN       = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rfshGnt,
  input  logic srEnter,
  output logic rfshReq,
  output logic busOwn,
  output logic initDone,
  output logic overdue,
  output logic srActive,
  output logic rasN,
  output logic casN
);
  seqCtl_t    seqCtl;
  logic       tmrZero, casHold, initLast;
  logic [1:0] owedCnt;

  dram_rfsh_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .rfshGnt(rfshGnt), .srEnter(srEnter),
    .tmrZero(tmrZero), .casHold(casHold), .initLast(initLast), .owedCnt(owedCnt),
    .ctl(seqCtl), .initDone(initDone), .rfshReq(rfshReq), .busOwn(busOwn),
    .overdue(overdue), .srActive(srActive), .rasN(rasN), .casN(casN)
  );

  dram_rfsh_dp #(
    .INIT_PAUSE(INIT_PAUSE), .INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(REF_INTERVAL),
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RPS(T_RPS),
    .SR_MIN(SR_MIN)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(seqCtl), .initDone(initDone),
    .tmrZero(tmrZero), .casHold(casHold), .initLast(initLast), .owedCnt(owedCnt)
  );
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int SR_MIN    = 20000,
  parameter int FORBID_LO = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic rfshGnt,
  input logic rfshReq,
  input logic busOwn,
  input logic initDone,
  input logic overdue,
  input logic srActive,
  input logic rasN,
  input logic casN
);
  int lowCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lowCnt <= 0;
    else if (rasN) lowCnt <= 0;
    else           lowCnt <= lowCnt + 1;
  end

  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !initDone |-> busOwn && !rfshReq); // R1
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rasN) |-> !casN && $past(!casN)); // R3
  AST_CAS_HIGH_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rasN) |-> casN); // R3
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    initDone && $past(initDone) && $rose(busOwn) |-> $past(rfshGnt)); // R6
  AST_OVERDUE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    overdue |-> rfshReq); // R7
  AST_SR_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    srActive |-> busOwn && !rasN && !casN); // R8
  AST_NO_FORBIDDEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rasN) |-> (lowCnt < FORBID_LO) || (lowCnt >= SR_MIN)); // R11
endmodule

bind dram_refresh_seq dram_refresh_chk #(.SR_MIN(SR_MIN), .FORBID_LO(SR_MIN / 10)) u_chk (
  .clk(clk), .rst_n(rst_n), .rfshGnt(rfshGnt), .rfshReq(rfshReq), .busOwn(busOwn),
  .initDone(initDone), .overdue(overdue), .srActive(srActive), .rasN(rasN), .casN(casN)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
  localparam int INIT_PAUSE = 40, INIT_CYCLES = 8, REF_INTERVAL = 60;
  localparam int T_CSR = 1, T_CHR = 2, T_RAS = 10, T_RP = 8, T_RPS = 20, SR_MIN = 200;

  logic clk = 1'b0, rst_n = 1'b0, rfshGnt = 1'b0, srEnter = 1'b0;
  logic rfshReq, busOwn, initDone, overdue, srActive, rasN, casN;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .INIT_PAUSE(INIT_PAUSE), .INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(REF_INTERVAL),
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP), .T_RPS(T_RPS), .SR_MIN(SR_MIN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rfshGnt(rfshGnt), .srEnter(srEnter), .rfshReq(rfshReq),
    .busOwn(busOwn), .initDone(initDone), .overdue(overdue), .srActive(srActive),
    .rasN(rasN), .casN(casN)
  );

  typedef struct { bit selfRef; int width; } expItem_t;
  expItem_t expQ[$];

  int checks = 0, errors = 0, cyc = 0;
  int fallCnt = 0, lastFall = 0, prevFall = 0, lowAge = 0;
  int firstFall = -1;
  bit finished = 1'b0;
  logic rasPrev = 1'b1, casPrev = 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushExp(input bit selfRef, input int width);
    expItem_t it;
    it.selfRef = selfRef; it.width = width;
    expQ.push_back(it);
  endtask

  // monitor: strobe timing and scoreboard of RAS-low widths
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (rasPrev && !rasN) begin
        prevFall = lastFall; lastFall = cyc; fallCnt++;
        if (firstFall < 0) firstFall = cyc;
        check(!casN && !casPrev, "R3 CAS low before RAS fall", int'(casPrev), 0);
        lowAge = 0;
      end
      if (!rasN) begin
        lowAge++;
        if (lowAge <= T_CHR && casN) check(1'b0, "R3 CAS hold after RAS fall", 1, 0);
      end
      if (!rasPrev && rasN) begin
        expItem_t it;
        if (expQ.size() > 0) it = expQ.pop_front();
        else begin it.selfRef = 1'b0; it.width = T_RAS; end
        if (it.selfRef) check(lowAge >= it.width, "R8 self-refresh RAS low width", lowAge, it.width);
        else            check(lowAge == it.width, "R4 RAS low width", lowAge, it.width);
        check(casN == 1'b1, "R3 CAS high at RAS rise", int'(casN), 1);
      end
      rasPrev = rasN; casPrev = casN;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0, gap, cnt;
    repeat (3) @(negedge clk);
    check(rasN && casN && busOwn && !initDone && !rfshReq && !overdue && !srActive,
          "R1 reset state", {rasN, casN, busOwn, initDone, rfshReq}, 5'b11100);
    for (int i = 0; i < INIT_CYCLES; i++) pushExp(1'b0, T_RAS);
    rst_n = 1'b1;

    // R1/R2: pause, then dummy cycles without grant
    wait (initDone);
    @(negedge clk);
    check(firstFall >= INIT_PAUSE, "R1 power-up pause", firstFall, INIT_PAUSE);
    check(fallCnt == INIT_CYCLES, "R2 init cycle count", fallCnt, INIT_CYCLES);
    check(!busOwn && !rfshReq, "R2 bus released after init", int'(busOwn), 0);

    // R5: periodic refresh with grant held
    rfshGnt = 1'b1;
    wait (fallCnt == INIT_CYCLES + 2);
    @(negedge clk);
    check(lastFall - prevFall == REF_INTERVAL, "R5 refresh spacing", lastFall - prevFall, REF_INTERVAL);
    check(lastFall - prevFall >= T_RAS + T_RP, "R4 precharge gap", lastFall - prevFall, T_RAS + T_RP);

    // R6/R7: starve the grant across two intervals
    wait (!busOwn);
    @(negedge clk);
    rfshGnt = 1'b0;
    f0 = fallCnt;
    wait (overdue);
    @(negedge clk);
    check(fallCnt == f0 && rasN, "R6 no refresh without grant", fallCnt, f0);
    check(rfshReq == 1'b1, "R6 request held while waiting", int'(rfshReq), 1);
    check(overdue && rfshReq, "R7 overdue with request", int'(overdue), 1);
    rfshGnt = 1'b1;
    wait (fallCnt == f0 + 2);
    @(negedge clk);
    gap = lastFall - prevFall;
    check(gap == T_CSR + T_RAS + T_RP + 1, "R7 back-to-back refresh", gap, T_CSR + T_RAS + T_RP + 1);
    wait (!busOwn);
    @(negedge clk);
    check(!overdue && !rfshReq, "R7 owed cleared", {overdue, rfshReq}, 0);

    // R8/R9/R10: self refresh while a refresh is owed
    rfshGnt = 1'b0;
    wait (rfshReq);
    @(negedge clk);
    pushExp(1'b1, SR_MIN);
    srEnter = 1'b1;
    rfshGnt = 1'b1;
    wait (srActive);
    repeat (20) @(negedge clk);
    srEnter = 1'b0;
    check(srActive && !rasN && !casN, "R8 held in self refresh after early release",
          {srActive, rasN, casN}, 3'b100);
    wait (!srActive);
    @(negedge clk);
    cnt = 0;
    while (busOwn) begin
      if (!rasN || !casN) check(1'b0, "R9 strobes high in exit precharge", {rasN, casN}, 2'b11);
      cnt++;
      @(negedge clk);
    end
    check(cnt == T_RPS, "R9 exit precharge length", cnt, T_RPS);
    check(!rfshReq, "R10 owed refresh discarded", int'(rfshReq), 0);
    f0 = fallCnt;
    repeat (REF_INTERVAL / 2) @(negedge clk);
    check(!rfshReq && fallCnt == f0, "R10 interval restarted", fallCnt, f0);
    check(expQ.size() == 0, "R8 scoreboard drained", expQ.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule